// File: doc/BRIEF.md
# Host Interrupt Enable and Clear Controller

This block produces the single interrupt request that a host-bus bridge receives from a DSP carrier board. Four sources feed it. Three of them are captured in sticky flags: the host comport input register filling with DSP data, the host comport register finishing its transmission, and an interrupt programmed by the DSP. The fourth is the scan test-bus controller request, which is passed through as a level and is never captured.

A write-only control word sets the per-source enables and the three DSP-to-PC interrupt-line enables. In the same write it clears captured flags by writing one to their clear bits. The combined request goes to exactly one of three bus interrupt pins, or to none, according to a 2-bit routing setting. A low status byte read from the board can be written straight back into the control word without side effects.

Top module: `host_irq_ctrl`

## Requirements
- R1: A synchronous active-low reset clears all enables and all captured flags. While reset is low and on the cycle after it, `irq_out`, `irq_line` and `dsp_pc_en` are all zero.
- R2: A write (`wr_en` high at a rising edge) replaces every enable with the written data. Bits 10:8 appear on `dsp_pc_en[2:0]` after that edge.
- R3: `obe_evt`, `ibf_evt` and `dsp_evt` each set their captured flag at the edge where they are high, whatever the enable. A flag captured while its source was disabled raises `irq_out` once that source is enabled.
- R4: `irq_out` is the OR of each captured flag ANDed with its enable, together with `tbc_irq` ANDed with its enable. The enable bits are: bit 0 output-empty, bit 1 input-full, bit 2 test-bus, bit 3 DSP interrupt.
- R5: Writing one clears the matching captured flag: bit 4 clears output-empty, bit 5 clears input-full, bit 7 clears DSP interrupt. A zero in a clear bit leaves its flag unchanged.
- R6: When a source event and a write clearing that source coincide, the flag stays set.
- R7: The test-bus request is not captured. With its enable set, `irq_out` follows `tbc_irq` and falls as soon as `tbc_irq` falls.
- R8: Bit 6 of the write data has no effect.
- R9: `route_sel` value 0 drives `irq_line[0]` (line A), value 1 drives `irq_line[1]` (line B), value 2 drives `irq_line[2]` (line C), and value 3 drives no line. The unselected lines stay low.
- R10: Writing back a status byte (enables in bits 3:0, pending output-empty in bit 4, input-full in bit 5, DSP interrupt in bit 7) keeps the enables as they are and clears exactly the flags shown pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 11 | Control-word write data |
| obe_evt | input | 1 | Comport output-empty event pulse |
| ibf_evt | input | 1 | Comport input-full event pulse |
| tbc_irq | input | 1 | Test-bus controller request level |
| dsp_evt | input | 1 | DSP-programmed interrupt event pulse |
| route_sel | input | 2 | Interrupt pin routing setting |
| irq_out | output | 1 | Combined interrupt request |
| irq_line | output | 3 | Routed interrupt pins A, B, C |
| dsp_pc_en | output | 3 | DSP-to-PC interrupt-line enables |

## Verification
The combining logic is driven in several ways: events that arrive while their source is disabled and are enabled later, events that arrive together with their enable, and events that coincide with their own clear. These cases separate a capture that is gated by the enable from one that is not, and a set-dominant flag from a clear-dominant one. The test-bus level is raised and then dropped, which shows that it is passed through and never captured. The routing setting is changed while a request is active, so that each of the four values is seen on its own pin pattern. A status write-back and a reset in the middle of operation show that the enables survive the write-back and that the reset clears the captured state.

// File: rtl/host_irq_pkg.sv
// Package: field positions of the host interrupt control word.
// Assumes an 11-bit write-only word. Clear bits sit directly above the enables.
package host_irq_pkg;
    localparam int CTRL_W    = 11;
    localparam int N_SRC     = 4;   // enable bits 3:0
    localparam int N_STICKY  = 3;   // captured sources: output-empty, input-full, DSP
    localparam int N_PC      = 3;   // DSP-to-PC line enables
    localparam int N_LINES   = 3;   // bus interrupt pins A, B, C
    localparam int ROUTE_W   = $clog2(N_LINES + 1);
    localparam int PC_LSB    = 8;

    // enable bit of each source
    localparam int EN_OBE    = 0;
    localparam int EN_IBF    = 1;
    localparam int EN_TBC    = 2;
    localparam int EN_DSP    = 3;

    // clear bit for each sticky index (0 output-empty, 1 input-full, 2 DSP)
    localparam int CLR_POS [N_STICKY] = '{4, 5, 7};
    // enable bit for each sticky index
    localparam int STK_EN  [N_STICKY] = '{EN_OBE, EN_IBF, EN_DSP};
endpackage

// File: rtl/host_irq_ctrl_reg.sv
// Module: control-word register. Holds the source enables and the DSP-to-PC
// enables, and decodes the write-one-to-clear pulses.
// Assumes a single-cycle write strobe. Clear and reserved bits are not stored.
module host_irq_ctrl_reg
    import host_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CTRL_W-1:0]   wr_data,
    output logic [N_SRC-1:0]    src_en,
    output logic [N_PC-1:0]     pc_en,
    output logic [N_STICKY-1:0] clr_pulse
);
    // Store enables on every write; reset zeroes them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_en <= '0;
            pc_en  <= '0;
        end else if (wr_en) begin
            src_en <= wr_data[N_SRC-1:0];
            pc_en  <= wr_data[PC_LSB +: N_PC];
        end
    end

    // Decode the clear pulse of each sticky source from its own bit.
    for (genvar i = 0; i < N_STICKY; i++) begin : g_clr
        assign clr_pulse[i] = wr_en & wr_data[CLR_POS[i]];
    end
endmodule

// File: rtl/host_irq_sticky.sv
// Module: bank of set-dominant sticky event flags.
// Assumes single-cycle or level events. A set in the same cycle as a clear keeps the flag.
module host_irq_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Capture one event. The set takes priority over the clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_q[i] <= 1'b0;
            else if (set_i[i]) flag_q[i] <= 1'b1;
            else if (clr_i[i]) flag_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/host_irq_router.sv
// Module: steers one request onto one of N bus pins.
// Assumes that a select value of N or above means no pin is driven.
module host_irq_router #(
    parameter int N     = 3,
    parameter int SEL_W = $clog2(N + 1)
) (
    input  logic             req,
    input  logic [SEL_W-1:0] sel,
    output logic [N-1:0]     pin
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        // Drive pin i only when it is the selected one.
        assign pin[i] = req && (sel == SEL_W'(i));
    end
endmodule

// File: rtl/host_irq_ctrl.sv
// Module: host interrupt enable/clear controller (top).
// Captures the output-empty, input-full and DSP events, passes the test-bus
// level through, gates every source with its enable, and routes the OR.
// Assumes that all inputs are synchronous to clk.
module host_irq_ctrl
    import host_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CTRL_W-1:0]   wr_data,
    input  logic                obe_evt,
    input  logic                ibf_evt,
    input  logic                tbc_irq,
    input  logic                dsp_evt,
    input  logic [ROUTE_W-1:0]  route_sel,
    output logic                irq_out,
    output logic [N_LINES-1:0]  irq_line,
    output logic [N_PC-1:0]     dsp_pc_en
);
    logic [N_SRC-1:0]    en_q;
    logic [N_STICKY-1:0] clr_pulse;
    logic [N_STICKY-1:0] set_vec;
    logic [N_STICKY-1:0] pend_q;
    logic [N_STICKY-1:0] gated;

    host_irq_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .src_en    (en_q),
        .pc_en     (dsp_pc_en),
        .clr_pulse (clr_pulse)
    );

    // Gather the sticky event inputs in sticky-index order.
    assign set_vec = {dsp_evt, ibf_evt, obe_evt};

    host_irq_sticky #(.N(N_STICKY)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_pulse),
        .flag_q (pend_q)
    );

    for (genvar i = 0; i < N_STICKY; i++) begin : g_gate
        assign gated[i] = pend_q[i] & en_q[STK_EN[i]];
    end

    // Combine the gated sticky flags with the pass-through test-bus level.
    assign irq_out = (|gated) | (tbc_irq & en_q[EN_TBC]);

    host_irq_router #(.N(N_LINES), .SEL_W(ROUTE_W)) u_route (
        .req (irq_out),
        .sel (route_sel),
        .pin (irq_line)
    );
endmodule

// File: rtl/host_irq_ctrl_chk.sv
// Module: assertion checker for host_irq_ctrl, attached through bind.
// Assumes that en_q and pend_q are the top's enable and sticky-flag vectors.
module host_irq_ctrl_chk
    import host_irq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [CTRL_W-1:0]   wr_data,
    input logic                obe_evt,
    input logic [ROUTE_W-1:0]  route_sel,
    input logic                irq_out,
    input logic [N_LINES-1:0]  irq_line,
    input logic [N_PC-1:0]     dsp_pc_en,
    input logic [N_SRC-1:0]    en_q,
    input logic [N_STICKY-1:0] pend_q
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!irq_out && dsp_pc_en == '0 && pend_q == '0));

    a_r2_pc_en_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> dsp_pc_en == $past(wr_data[PC_LSB +: N_PC]));

    a_r4_all_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_out);

    a_r5_clear_obe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CLR_POS[0]] && !obe_evt) |=> !pend_q[0]);

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        obe_evt |=> pend_q[0]);

    a_r9_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_line));

    a_r9_pin_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (route_sel < ROUTE_W'(N_LINES)) |-> ($countones(irq_line) == 32'(irq_out)));
endmodule

bind host_irq_ctrl host_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .obe_evt   (obe_evt),
    .route_sel (route_sel),
    .irq_out   (irq_out),
    .irq_line  (irq_line),
    .dsp_pc_en (dsp_pc_en),
    .en_q      (en_q),
    .pend_q    (pend_q)
);

// File: tb/tb_host_irq_ctrl.sv
// Bench: a vector table walked by one loop, then directed reset and write-back tests.
module tb_host_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [10:0] wr_data;
    logic        obe_evt, ibf_evt, tbc_irq, dsp_evt;
    logic [1:0]  route_sel;
    logic        irq_out;
    logic [2:0]  irq_line;
    logic [2:0]  dsp_pc_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .obe_evt(obe_evt), .ibf_evt(ibf_evt), .tbc_irq(tbc_irq), .dsp_evt(dsp_evt),
        .route_sel(route_sel), .irq_out(irq_out), .irq_line(irq_line),
        .dsp_pc_en(dsp_pc_en)
    );

    // {wr_en, wr_data[10:0], evt{obe,ibf,tbc,dsp}, route, exp_irq, exp_line, exp_pc}
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 11'h000, 4'b0000, 2'd0, 1'b0, 3'b000, 3'b000}, // R1 idle after reset
        {1'b0, 11'h000, 4'b1000, 2'd0, 1'b0, 3'b000, 3'b000}, // R3 event while disabled
        {1'b1, 11'h001, 4'b0000, 2'd0, 1'b1, 3'b001, 3'b000}, // R3 enable shows captured flag
        {1'b0, 11'h000, 4'b0000, 2'd1, 1'b1, 3'b010, 3'b000}, // R9 route to B
        {1'b1, 11'h011, 4'b0000, 2'd1, 1'b0, 3'b000, 3'b000}, // R5 clear output-empty
        {1'b1, 11'h00F, 4'b0100, 2'd0, 1'b1, 3'b001, 3'b000}, // R4 input-full with enable
        {1'b1, 11'h02F, 4'b0100, 2'd0, 1'b1, 3'b001, 3'b000}, // R6 set beats clear
        {1'b1, 11'h02F, 4'b0000, 2'd0, 1'b0, 3'b000, 3'b000}, // R5 clear input-full
        {1'b0, 11'h000, 4'b0010, 2'd2, 1'b1, 3'b100, 3'b000}, // R7 test-bus level, route C
        {1'b0, 11'h000, 4'b0000, 2'd2, 1'b0, 3'b000, 3'b000}, // R7 level dropped
        {1'b0, 11'h000, 4'b0001, 2'd3, 1'b1, 3'b000, 3'b000}, // R9 route 3 drives none
        {1'b1, 11'h04F, 4'b0000, 2'd0, 1'b1, 3'b001, 3'b000}, // R8 reserved bit ignored
        {1'b1, 11'h08F, 4'b0000, 2'd0, 1'b0, 3'b000, 3'b000}, // R5 clear DSP interrupt
        {1'b1, 11'h700, 4'b0010, 2'd0, 1'b0, 3'b000, 3'b111}, // R2 line enables, test-bus off
        {1'b1, 11'h000, 4'b0000, 2'd0, 1'b0, 3'b000, 3'b000}  // R2 line enables cleared
    };
    localparam int VREQ [NV] = '{1, 3, 3, 9, 5, 4, 6, 5, 7, 7, 9, 8, 5, 2, 2};

    // Compare one observation and log a failure.
    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Drive idle values on all inputs.
    task automatic idle();
        wr_en = 1'b0; wr_data = '0;
        obe_evt = 1'b0; ibf_evt = 1'b0; tbc_irq = 1'b0; dsp_evt = 1'b0;
    endtask

    function automatic logic [6:0] obs();
        return {irq_out, irq_line, dsp_pc_en};
    endfunction

    // End a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // Main stimulus: reset, vector loop, directed tests.
    initial begin
        idle();
        route_sel = 2'd0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", obs(), 7'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            {wr_en, wr_data, obe_evt, ibf_evt, tbc_irq, dsp_evt, route_sel} = VEC[v][24:7];
            @(negedge clk);
            chk($sformatf("R%0d vec%0d", VREQ[v], v), obs(), VEC[v][6:0]);
            idle();
        end

        // R10: write back a status byte with output-empty and DSP pending.
        route_sel = 2'd0;
        wr_en = 1'b1; wr_data = 11'h009;
        @(negedge clk); idle();
        obe_evt = 1'b1; dsp_evt = 1'b1;
        @(negedge clk); idle();
        chk("R10 pending before write-back", obs(), 7'b1_001_000);
        wr_en = 1'b1; wr_data = 11'h099;
        @(negedge clk); idle();
        chk("R10 flags cleared by write-back", obs(), 7'b0_000_000);
        obe_evt = 1'b1;
        @(negedge clk); idle();
        chk("R10 enables kept after write-back", obs(), 7'b1_001_000);

        // R1: reset in the middle of operation with enables and a flag set.
        wr_en = 1'b1; wr_data = 11'h70F;
        @(negedge clk); idle();
        chk("R2 enables before reset", obs(), 7'b1_001_111);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears outputs", obs(), 7'b0);
        rst_n = 1'b1;
        wr_en = 1'b1; wr_data = 11'h001;
        @(negedge clk); idle();
        chk("R1 flag cleared by reset", obs(), 7'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule